// File: doc/BRIEF.md
# Dual-Channel Serial Audio Converter Input Port

This block is the digital front end of a stereo voltage-output audio converter. The left and right channels share one bit clock. Each has its own serial data line and its own latch line. Every rising bit-clock edge shifts one data bit into each channel's 18-bit shift register, most significant bit first. When a channel's latch line falls, the 18 bits most recently shifted into that channel are copied into its holding register. The holding register drives the converter. A one-cycle update strobe marks each copy.

The held two's-complement word is also encoded into the drive code for a partially segmented converter core. First the sign bit is inverted, which gives offset binary. The top three bits of that offset word then become a seven-line thermometer code for equal-weight elements. The low fifteen bits pass through unchanged to a binary ladder. The word length sent by the source does not have to be 18: longer words lose their leading bits, and shorter words keep stale upper bits. Both latch lines may be wired together, and so may both data lines.

All logic runs on the bit clock. Each latch input is compared against a registered copy of itself to find its falling edge.

Top module: `sdp_dual_port`

## Requirements
- R1: On every rising clock edge outside reset, each channel samples its data input into its shift register. Bits enter most significant first, so the bit sampled last becomes bit 0 of the word.
- R2: A falling latch edge is detected on the clock edge where the latch input is sampled low and was sampled high on the edge before. On that edge the holding word takes the 18 bits sampled on the 18 preceding edges. The bit sampled on the detecting edge itself is not included.
- R3: The update strobe of a channel is high for exactly the one cycle after each detected falling edge, and low otherwise.
- R4: A falling edge on one channel's latch leaves the other channel's holding word and strobe unchanged.
- R5: When more than 18 bits arrive between captures, only the last 18 are held.
- R6: When fewer than 18 bits arrive between captures, the new bits fill the low positions. The upper positions keep the bits that were shifted in earlier.
- R7: While reset is high, and after it until the first capture, the holding word is 0 (mid-scale), the thermometer output is 7'b0001111, the binary output is 0 and the strobe is low.
- R8: The segment field is the holding word's top three bits with bit 17 inverted (offset binary). Thermometer line k-1 (k = 1..7) is high exactly when this field is at least k. Code 0x1FFFF therefore gives 7'h7F, and code 0x20000 gives 7'h00.
- R9: The binary output always equals bits 14..0 of the holding word.
- R10: When the two data lines are tied together and the two latch lines are tied together, both channels hold identical words and strobe together.
- R11: A latch held high, a latch held low, or a rising latch edge never changes the holding word and never raises the strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shared serial bit clock |
| rst | input | 1 | Active-high asynchronous reset |
| l_data | input | 1 | Left serial data |
| l_latch | input | 1 | Left latch; its falling edge captures a word |
| r_data | input | 1 | Right serial data |
| r_latch | input | 1 | Right latch; its falling edge captures a word |
| l_word | output | 18 | Left held two's-complement word |
| l_therm | output | 7 | Left thermometer code for the segmented elements |
| l_bin | output | 15 | Left binary ladder bits |
| l_upd | output | 1 | Left one-cycle update strobe |
| r_word | output | 18 | Right held two's-complement word |
| r_therm | output | 7 | Right thermometer code for the segmented elements |
| r_bin | output | 15 | Right binary ladder bits |
| r_upd | output | 1 | Right one-cycle update strobe |

## Verification
A latch input driven low before rising edge N is detected on edge N. The holding word and the strobe change on that same edge, so both are read at the falling clock edge that follows. The thermometer and binary outputs are combinational from the holding word and are due in that same cycle. The bench drives inputs on falling edges and updates its queue-based model on rising edges. It compares all outputs at the next falling edge, so every expected value is already lined up with the one register between input and output.

// File: rtl/sdp_pkg.sv
package sdp_pkg;
  localparam int WORD_W  = 18;
  localparam int SEG_W   = 3;
  localparam int BIN_W   = WORD_W - SEG_W;
  localparam int THERM_W = (1 << SEG_W) - 1;
  localparam int NCH     = 2;

  // two's complement to offset binary: flip the sign bit
  function automatic logic [WORD_W-1:0] to_offset(input logic [WORD_W-1:0] w);
    return {~w[WORD_W-1], w[WORD_W-2:0]};
  endfunction

  // segment field taken from the offset-binary word
  function automatic logic [SEG_W-1:0] seg_field(input logic [WORD_W-1:0] w);
    logic [WORD_W-1:0] o;
    o = to_offset(w);
    return o[WORD_W-1 -: SEG_W];
  endfunction
endpackage

// File: rtl/sdp_latch_edge.sv
module sdp_latch_edge (
  input  logic clk,
  input  logic rst,
  input  logic lat_i,
  output logic fall_o
);
  logic lat_q;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) lat_q <= 1'b0;
    else     lat_q <= lat_i;
  end

  assign fall_o = lat_q & ~lat_i;
endmodule

// File: rtl/sdp_shift_reg.sv
module sdp_shift_reg #(
  parameter int WORD_W = sdp_pkg::WORD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_i,
  output logic [WORD_W-1:0] word_o
);
  logic [WORD_W-1:0] sr;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) sr <= '0;
    else     sr <= {sr[WORD_W-2:0], bit_i};
  end

  assign word_o = sr;
endmodule

// File: rtl/sdp_hold_reg.sv
module sdp_hold_reg #(
  parameter int WORD_W = sdp_pkg::WORD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cap_i,
  input  logic [WORD_W-1:0] word_i,
  output logic [WORD_W-1:0] hold_o,
  output logic              upd_o
);
  logic [WORD_W-1:0] hold;
  logic              upd;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      hold <= '0;
      upd  <= 1'b0;
    end else begin
      upd <= cap_i;
      if (cap_i) hold <= word_i;
    end
  end

  assign hold_o = hold;
  assign upd_o  = upd;
endmodule

// File: rtl/sdp_seg_enc.sv
module sdp_seg_enc #(
  parameter int WORD_W = sdp_pkg::WORD_W,
  parameter int SEG_W  = sdp_pkg::SEG_W
) (
  input  logic [WORD_W-1:0]          word_i,
  output logic [(1<<SEG_W)-2:0]      therm_o,
  output logic [WORD_W-SEG_W-1:0]    bin_o
);
  localparam int THERM_W = (1 << SEG_W) - 1;
  localparam int BIN_W   = WORD_W - SEG_W;

  logic [SEG_W-1:0] field;
  assign field = sdp_pkg::seg_field(word_i);

  for (genvar k = 1; k <= THERM_W; k++) begin : g_therm
    assign therm_o[k-1] = (int'(field) >= k);
  end

  assign bin_o = word_i[BIN_W-1:0];
endmodule

// File: rtl/sdp_dual_port.sv
module sdp_dual_port #(
  parameter int WORD_W = sdp_pkg::WORD_W,
  parameter int SEG_W  = sdp_pkg::SEG_W
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       l_data,
  input  logic                       l_latch,
  input  logic                       r_data,
  input  logic                       r_latch,
  output logic [WORD_W-1:0]          l_word,
  output logic [(1<<SEG_W)-2:0]      l_therm,
  output logic [WORD_W-SEG_W-1:0]    l_bin,
  output logic                       l_upd,
  output logic [WORD_W-1:0]          r_word,
  output logic [(1<<SEG_W)-2:0]      r_therm,
  output logic [WORD_W-SEG_W-1:0]    r_bin,
  output logic                       r_upd
);
  localparam int NCH     = sdp_pkg::NCH;
  localparam int THERM_W = (1 << SEG_W) - 1;
  localparam int BIN_W   = WORD_W - SEG_W;

  logic [NCH-1:0]              data_v, latch_v, fall_v, upd_v;
  logic [NCH-1:0][WORD_W-1:0]  shift_v, hold_v;
  logic [NCH-1:0][THERM_W-1:0] therm_v;
  logic [NCH-1:0][BIN_W-1:0]   bin_v;

  // named internal events, used by the bound checker
  logic l_fall, r_fall;

  assign data_v  = {r_data, l_data};
  assign latch_v = {r_latch, l_latch};

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    sdp_latch_edge u_edge (
      .clk    (clk),
      .rst    (rst),
      .lat_i  (latch_v[c]),
      .fall_o (fall_v[c])
    );

    sdp_shift_reg #(.WORD_W(WORD_W)) u_shift (
      .clk    (clk),
      .rst    (rst),
      .bit_i  (data_v[c]),
      .word_o (shift_v[c])
    );

    sdp_hold_reg #(.WORD_W(WORD_W)) u_hold (
      .clk    (clk),
      .rst    (rst),
      .cap_i  (fall_v[c]),
      .word_i (shift_v[c]),
      .hold_o (hold_v[c]),
      .upd_o  (upd_v[c])
    );

    sdp_seg_enc #(.WORD_W(WORD_W), .SEG_W(SEG_W)) u_enc (
      .word_i  (hold_v[c]),
      .therm_o (therm_v[c]),
      .bin_o   (bin_v[c])
    );
  end

  assign l_fall  = fall_v[0];
  assign r_fall  = fall_v[1];

  assign l_word  = hold_v[0];
  assign l_therm = therm_v[0];
  assign l_bin   = bin_v[0];
  assign l_upd   = upd_v[0];
  assign r_word  = hold_v[1];
  assign r_therm = therm_v[1];
  assign r_bin   = bin_v[1];
  assign r_upd   = upd_v[1];
endmodule

// File: rtl/sdp_dual_port_chk.sv
module sdp_dual_port_chk (
  input logic        clk,
  input logic        rst,
  input logic        l_latch,
  input logic        r_latch,
  input logic        l_fall,
  input logic        r_fall,
  input logic [17:0] l_word,
  input logic [6:0]  l_therm,
  input logic [14:0] l_bin,
  input logic        l_upd,
  input logic [17:0] r_word,
  input logic [6:0]  r_therm,
  input logic [14:0] r_bin,
  input logic        r_upd
);
  assert_l_strobe_follows_fall_R3: assert property (@(posedge clk) disable iff (rst)
    l_fall |=> l_upd);
  assert_r_strobe_follows_fall_R3: assert property (@(posedge clk) disable iff (rst)
    r_fall |=> r_upd);
  assert_l_strobe_single_R3: assert property (@(posedge clk) disable iff (rst)
    l_upd |=> !l_upd);
  assert_l_strobe_latch_low_R2: assert property (@(posedge clk) disable iff (rst)
    l_upd |-> $past(!l_latch));
  assert_r_strobe_latch_low_R2: assert property (@(posedge clk) disable iff (rst)
    r_upd |-> $past(!r_latch));
  assert_l_word_stable_R11: assert property (@(posedge clk) disable iff (rst)
    !l_upd |-> $stable(l_word));
  assert_r_word_stable_R11: assert property (@(posedge clk) disable iff (rst)
    !r_upd |-> $stable(r_word));
  assert_r_untouched_by_left_R4: assert property (@(posedge clk) disable iff (rst)
    (l_fall && !r_fall) |=> $stable(r_word));
  assert_l_therm_count_R8: assert property (@(posedge clk) disable iff (rst)
    $countones(l_therm) == int'(unsigned'({~l_word[17], l_word[16:15]})));
  assert_r_therm_count_R8: assert property (@(posedge clk) disable iff (rst)
    $countones(r_therm) == int'(unsigned'({~r_word[17], r_word[16:15]})));
  assert_l_therm_contig_R8: assert property (@(posedge clk) disable iff (rst)
    ((l_therm + 7'd1) & l_therm) == 7'd0);
  assert_l_bin_R9: assert property (@(posedge clk) disable iff (rst)
    l_bin == l_word[14:0]);
  assert_r_bin_R9: assert property (@(posedge clk) disable iff (rst)
    r_bin == r_word[14:0]);
endmodule

bind sdp_dual_port sdp_dual_port_chk u_chk (
  .clk     (clk),
  .rst     (rst),
  .l_latch (l_latch),
  .r_latch (r_latch),
  .l_fall  (l_fall),
  .r_fall  (r_fall),
  .l_word  (l_word),
  .l_therm (l_therm),
  .l_bin   (l_bin),
  .l_upd   (l_upd),
  .r_word  (r_word),
  .r_therm (r_therm),
  .r_bin   (r_bin),
  .r_upd   (r_upd)
);

// File: tb/sim_sdp_dual_port.sv
module sim_sdp_dual_port;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic l_data = 1'b0, l_latch = 1'b0, r_data = 1'b0, r_latch = 1'b0;
  logic [17:0] l_word, r_word;
  logic [6:0]  l_therm, r_therm;
  logic [14:0] l_bin, r_bin;
  logic        l_upd, r_upd;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  sdp_dual_port u0 (
    .clk(clk), .rst(rst),
    .l_data(l_data), .l_latch(l_latch), .r_data(r_data), .r_latch(r_latch),
    .l_word(l_word), .l_therm(l_therm), .l_bin(l_bin), .l_upd(l_upd),
    .r_word(r_word), .r_therm(r_therm), .r_bin(r_bin), .r_upd(r_upd)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit qa[$];
  bit qb[$];
  int ew[2];
  int eu[2];
  bit pl[2];

  function automatic int recent18(ref bit q[$]);
    int v = 0;
    for (int i = q.size() - 18; i < q.size(); i++) v = v * 2 + int'(q[i]);
    return v;
  endfunction

  function automatic int exp_therm(input int w);
    int seg = ((w ^ 32'h20000) / 32768) % 8;
    return (1 << seg) - 1;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      qa.delete(); qb.delete();
      for (int i = 0; i < 18; i++) begin qa.push_back(1'b0); qb.push_back(1'b0); end
      ew[0] = 0; ew[1] = 0; eu[0] = 0; eu[1] = 0; pl[0] = 0; pl[1] = 0;
    end else begin
      eu[0] = (pl[0] && !l_latch) ? 1 : 0;
      eu[1] = (pl[1] && !r_latch) ? 1 : 0;
      if (eu[0] == 1) ew[0] = recent18(qa);
      if (eu[1] == 1) ew[1] = recent18(qb);
      qa.push_back(l_data); qb.push_back(r_data);
      if (qa.size() > 18) void'(qa.pop_front());
      if (qb.size() > 18) void'(qb.pop_front());
      pl[0] = l_latch; pl[1] = r_latch;
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R2 left word",  int'(l_word), ew[0]);
      chk("R2 right word", int'(r_word), ew[1]);
      chk("R3 left strobe",  int'(l_upd), eu[0]);
      chk("R3 right strobe", int'(r_upd), eu[1]);
      chk("R8 left therm",  int'(l_therm), exp_therm(ew[0]));
      chk("R8 right therm", int'(r_therm), exp_therm(ew[1]));
      chk("R9 left bin",  int'(l_bin), ew[0] % 32768);
      chk("R9 right bin", int'(r_bin), ew[1] % 32768);
    end
  end

  // ---------------- stimulus ----------------
  // n bits MSB first; latch high alongside the last bit, low on the next cycle
  task automatic send(input int lv, input int rv, input int n, input bit ul, input bit ur);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      l_data  = ((lv >> (n - 1 - i)) & 1) != 0;
      r_data  = ((rv >> (n - 1 - i)) & 1) != 0;
      l_latch = ul && (i == n - 1);
      r_latch = ur && (i == n - 1);
    end
    @(negedge clk);
    l_latch = 1'b0; r_latch = 1'b0; l_data = 1'b0; r_data = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R7 reset word",  int'(l_word), 0);
    chk("R7 reset therm", int'(l_therm), 'h0F);
    chk("R7 reset bin",   int'(r_bin), 0);
    chk("R7 reset strobe", int'(l_upd | r_upd), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R7 after reset therm", int'(r_therm), 'h0F);

    // R1: MSB first; full-scale codes
    send('h1FFFF, 'h20000, 18, 1, 1);
    chk("R1 left word", int'(l_word), 'h1FFFF);
    chk("R1 right word", int'(r_word), 'h20000);
    chk("R8 full positive therm", int'(l_therm), 'h7F);
    chk("R8 full negative therm", int'(r_therm), 'h00);
    chk("R3 strobe after capture", int'(l_upd & r_upd), 1);
    @(negedge clk);
    chk("R3 strobe single cycle", int'(l_upd | r_upd), 0);

    // R5: 20 bits, first two dropped
    send(('h3 << 18) | 'h0ABCD, ('h3 << 18) | 'h2C3A5, 20, 1, 1);
    chk("R5 left long word", int'(l_word), 'h0ABCD);
    chk("R5 right long word", int'(r_word), 'h2C3A5);

    // R4: left latch only
    send('h12345, 'h3FFFF, 18, 1, 0);
    chk("R4 left captured", int'(l_word), 'h12345);
    chk("R4 right kept", int'(r_word), 'h2C3A5);
    chk("R4 right no strobe", int'(r_upd), 0);

    // R6: 10-bit word keeps stale upper bits
    send('h155, 'h2AA, 10, 1, 1);
    chk("R6 left low bits", int'(l_word) % 1024, 'h155);
    chk("R6 right low bits", int'(r_word) % 1024, 'h2AA);
    chk("R6 left stale upper", int'(l_word), ew[0]);

    // R11: latch held high, rising edge, no update
    @(negedge clk); l_latch = 1'b1; r_latch = 1'b1;
    for (int i = 0; i < 24; i++) begin
      @(negedge clk);
      l_data = (i % 3) == 0; r_data = (i % 2) == 0;
      chk("R11 no strobe while high", int'(l_upd | r_upd), 0);
      chk("R11 word held", int'(l_word), ew[0]);
    end
    @(negedge clk); l_latch = 1'b0; r_latch = 1'b0;
    repeat (20) begin
      @(negedge clk);
      chk("R11 no strobe while low", int'(l_upd | r_upd) & int'(eu[0] == 0 && eu[1] == 0), 0);
    end

    // R10: tied lines
    for (int j = 0; j < 4; j++) begin
      int v = (j * 'h1D3B7 + 'h00F0F) % 'h40000;
      send(v, v, 18, 1, 1);
      chk("R10 tied left", int'(l_word), v);
      chk("R10 tied match", int'(r_word), int'(l_word));
    end

    // mid-scale
    send(0, 'h3FFFF, 18, 1, 1);
    chk("R8 midscale therm", int'(l_therm), 'h0F);
    chk("R8 minus one therm", int'(r_therm), 'h07);

    // mixed random traffic, compared each cycle by the model
    for (int j = 0; j < 300; j++) begin
      int n = 14 + int'($urandom_range(0, 8));
      send(int'($urandom_range(0, 'hFFFFF)), int'($urandom_range(0, 'hFFFFF)), n,
           $urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule